// File: doc/BRIEF.md
# Multi-Plane Block Erase Command Decoder

This block models the command-receiving side of a single NAND die. Bytes arrive on an 8-bit bus and are captured on a one-cycle write strobe. A command-latch enable marks a byte as an opcode and an address-latch enable marks it as an address byte. The host sends a setup opcode, three row-address bytes and a confirm opcode. An intermediate confirm stores the addressed block in a per-plane queue and holds the die busy for a short interval. A final confirm adds its own block and then erases every queued block at once. While the die is busy, it drives its ready flags low and pulls the ready/busy line low.

When the erase time has passed, the block reports each erased block as one item on a valid/ready event stream. Items are sent in ascending plane order. The sender keeps an item valid and unchanged until the sink accepts it. Back-pressure from the sink only delays the report. The die stays busy until the last item has been accepted, and it is ready again one cycle after that acceptance.

Two status opcodes make a live status byte visible. A reset opcode aborts any activity and empties the queue. Encodings used throughout:
- Opcodes: setup 60h, intermediate confirm D1h, final confirm D0h, status 70h and 78h, reset FFh. Every other opcode is invalid.
- Row address: the first address byte is row[7:0], the second is row[15:8] and the third is row[23:16]. The page is row[5:0] and is ignored. The block is row[17:6] and the plane is block[1:0]. row[23:18] must be zero.
- Status byte: bit 6 is ready, bit 5 is array-ready and bit 0 is fail. All other bits read 0.

Top module: `nand_mp_erase`

## Requirements
- R1: After reset, rdy and ardy are 1, rb_drive_low is 0, stat_en is 0, ev_valid is 0 and the plane queue is empty.
- R2: The sequence 60h, three address bytes, D1h queues the block row[17:6] in plane row[7:6]. The page bits row[5:0] do not appear in the reported block.
- R3: After an accepted D1h, rdy and ardy are 0 for exactly SHORT_BUSY cycles. They then return to 1 and no event is produced.
- R4: After D0h, the die is busy for ERASE_BUSY cycles with no event. It then reports every queued block plus the final block, one event each.
- R5: A queue command to a plane that already holds a block replaces that block. Each plane reports at most one block.
- R6: Events come out in ascending plane order. ev_valid is only ever 1 while rdy is 0. ev_plane and ev_block stay stable while ev_valid is 1 and ev_ready is 0.
- R7: While the die is busy, setup, confirm, address and invalid bytes are ignored. The busy time is neither extended nor restarted, and the queue is unchanged.
- R8: After 70h or 78h, stat_en is 1 and stat_byte reads {0, rdy, ardy, 0000, fail}. rb_drive_low equals NOT rdy at all times.
- R9: D0h with an empty queue erases the single addressed block.
- R10: FFh is accepted at any time. It returns the die to ready at the next edge, empties the queue, clears fail and drops any pending erase or report.
- R11: An invalid opcode while ready empties the queue. A confirm that arrives without 60h and exactly three address bytes is also treated as invalid and does not make the die busy.
- R12: A confirm whose row[23:18] is nonzero sets fail, empties the queue and leaves the die ready. The next accepted 60h clears fail.
- R13: The queue is empty once an erase completes, so a later D0h reports only the blocks queued after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | One-cycle strobe that captures din |
| cle | input | 1 | Byte is an opcode |
| ale | input | 1 | Byte is an address byte (ignored when cle is 1) |
| din | input | 8 | Command/address byte |
| rdy | output | 1 | Die ready |
| ardy | output | 1 | Array ready |
| rb_drive_low | output | 1 | Open-drain enable: pull ready/busy line low |
| stat_en | output | 1 | Status byte is being presented |
| stat_byte | output | 8 | Live status byte |
| ev_valid | output | 1 | Erased-block event valid |
| ev_ready | input | 1 | Sink accepts the event |
| ev_plane | output | PLANE_BITS | Plane of the erased block |
| ev_block | output | BLOCK_BITS | Erased block address |

## Verification
The bench goes after four kinds of fault:
- Replacement within a plane: a design that appended entries instead of replacing them would report the stale block twice or in the wrong order.
- Opcodes sent during the short busy: a decoder that stayed armed while busy would start an erase early or add a plane that was never legitimately queued.
- Short address phases and out-of-range rows: a design that did not reject these would go busy or report a block that should have been discarded.
- Reset in the middle of an erase: a design that only stopped the timer would leak events afterwards.

The bench measures busy lengths edge by edge. It drives the event sink with a stalling pattern, so any early release or unstable payload shows up as a mismatch against the scoreboard.

// File: rtl/nand_mpe_pkg.sv
package nand_mpe_pkg;
  localparam logic [7:0] OP_SETUP    = 8'h60;
  localparam logic [7:0] OP_QUEUE    = 8'hD1;
  localparam logic [7:0] OP_GO       = 8'hD0;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_STAT_SEL = 8'h78;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  localparam int STAT_RDY_BIT  = 6;
  localparam int STAT_ARDY_BIT = 5;
  localparam int STAT_FAIL_BIT = 0;

  typedef enum logic [1:0] {
    PH_READY,
    PH_SHORT,
    PH_ERASE,
    PH_REPORT
  } phase_e;
endpackage

// File: rtl/nand_mpe_cmd_seq.sv
module nand_mpe_cmd_seq
  import nand_mpe_pkg::*;
#(
  parameter int ROW_BYTES  = 3,
  parameter int PAGE_BITS  = 6,
  parameter int BLOCK_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic                  cle,
  input  logic                  ale,
  input  logic [7:0]            din,
  input  logic                  accept,
  output logic                  cmd_strobe,
  output logic                  reset_hit,
  output logic                  stat_hit,
  output logic                  setup_hit,
  output logic                  queue_hit,
  output logic                  go_hit,
  output logic                  invalid_hit,
  output logic                  bad_hit,
  output logic [BLOCK_BITS-1:0] blk_out
);
  localparam int ROW_BITS = ROW_BYTES * 8;
  localparam int HI_BITS  = ROW_BITS - PAGE_BITS - BLOCK_BITS;
  localparam int CNT_W    = $clog2(ROW_BYTES + 1);

  logic                armed_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ROW_BITS-1:0] row_q;
  logic                addr_strobe;
  logic                full;
  logic                hi_set;
  logic                is_stat;

  assign cmd_strobe  = bus_we && cle;
  assign addr_strobe = bus_we && ale && !cle;
  assign full        = armed_q && (cnt_q == CNT_W'(ROW_BYTES));
  assign hi_set      = |row_q[ROW_BITS-1 -: HI_BITS];
  assign blk_out     = row_q[PAGE_BITS +: BLOCK_BITS];
  assign is_stat     = (din == OP_STAT) || (din == OP_STAT_SEL);

  always_comb begin
    reset_hit   = 1'b0;
    stat_hit    = 1'b0;
    setup_hit   = 1'b0;
    queue_hit   = 1'b0;
    go_hit      = 1'b0;
    invalid_hit = 1'b0;
    bad_hit     = 1'b0;
    if (cmd_strobe) begin
      case (din)
        OP_RESET:            reset_hit = 1'b1;
        OP_STAT, OP_STAT_SEL: stat_hit = 1'b1;
        OP_SETUP:            setup_hit = accept;
        OP_QUEUE, OP_GO: begin
          if (accept) begin
            if (!full)            invalid_hit = 1'b1;
            else if (hi_set)      bad_hit     = 1'b1;
            else if (din == OP_QUEUE) queue_hit = 1'b1;
            else                  go_hit      = 1'b1;
          end
        end
        default:             invalid_hit = accept;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (cmd_strobe) begin
      if (din == OP_RESET) begin
        armed_q <= 1'b0;
      end else if (setup_hit) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        row_q   <= '0;
      end else if (!is_stat && accept) begin
        armed_q <= 1'b0;
      end
    end else if (addr_strobe && armed_q && accept && (cnt_q < CNT_W'(ROW_BYTES))) begin
      row_q[int'(cnt_q)*8 +: 8] <= din;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nand_mpe_plane_q.sv
module nand_mpe_plane_q #(
  parameter int PLANE_BITS = 2,
  parameter int BLOCK_BITS = 12,
  localparam int PLANES    = 1 << PLANE_BITS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [PLANE_BITS-1:0]               wr_plane,
  input  logic [BLOCK_BITS-1:0]               wr_block,
  input  logic                                clr,
  input  logic                                take_en,
  input  logic [PLANE_BITS-1:0]               take_plane,
  output logic [PLANES-1:0]                   valid_mask,
  output logic [PLANES-1:0][BLOCK_BITS-1:0]   blocks
);
  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_mask[g] <= 1'b0;
        blocks[g]     <= '0;
      end else if (clr) begin
        valid_mask[g] <= 1'b0;
      end else if (wr_en && (wr_plane == PLANE_BITS'(g))) begin
        valid_mask[g] <= 1'b1;
        blocks[g]     <= wr_block;
      end else if (take_en && (take_plane == PLANE_BITS'(g))) begin
        valid_mask[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nand_mpe_timer.sv
module nand_mpe_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len_m1,
  input  logic             abort,
  output logic             running,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = running && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (abort) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt_q   <= len_m1;
    end else if (done) begin
      running <= 1'b0;
    end else if (running) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nand_mpe_pick.sv
module nand_mpe_pick #(
  parameter int PLANE_BITS = 2,
  localparam int PLANES    = 1 << PLANE_BITS
) (
  input  logic [PLANES-1:0]     mask,
  output logic                  any,
  output logic [PLANE_BITS-1:0] idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = PLANES - 1; i >= 0; i--) begin
      if (mask[i]) idx = PLANE_BITS'(i);
    end
  end
endmodule

// File: rtl/nand_mp_erase.sv
module nand_mp_erase
  import nand_mpe_pkg::*;
#(
  parameter int PLANE_BITS = 2,
  parameter int BLOCK_BITS = 12,
  parameter int PAGE_BITS  = 6,
  parameter int ROW_BYTES  = 3,
  parameter int SHORT_BUSY = 12,
  parameter int ERASE_BUSY = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic                  cle,
  input  logic                  ale,
  input  logic [7:0]            din,
  output logic                  rdy,
  output logic                  ardy,
  output logic                  rb_drive_low,
  output logic                  stat_en,
  output logic [7:0]            stat_byte,
  output logic                  ev_valid,
  input  logic                  ev_ready,
  output logic [PLANE_BITS-1:0] ev_plane,
  output logic [BLOCK_BITS-1:0] ev_block
);
  localparam int PLANES = 1 << PLANE_BITS;
  localparam int MAXB   = (SHORT_BUSY > ERASE_BUSY) ? SHORT_BUSY : ERASE_BUSY;
  localparam int TW     = $clog2(MAXB + 1);

  phase_e phase_q;
  logic   fail_q;
  logic   stat_en_q;

  logic cmd_strobe, reset_hit, stat_hit, setup_hit;
  logic queue_hit, go_hit, invalid_hit, bad_hit;
  logic [BLOCK_BITS-1:0] blk;

  logic [PLANES-1:0]                 vmask;
  logic [PLANES-1:0][BLOCK_BITS-1:0] blocks;
  logic                              any_q;
  logic [PLANE_BITS-1:0]             pick_idx;
  logic                              take;
  logic                              t_running, t_done;

  assign rdy          = (phase_q == PH_READY);
  assign ardy         = (phase_q == PH_READY);
  assign rb_drive_low = (phase_q != PH_READY);

  nand_mpe_cmd_seq #(
    .ROW_BYTES(ROW_BYTES), .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cle(cle), .ale(ale), .din(din),
    .accept(rdy), .cmd_strobe(cmd_strobe), .reset_hit(reset_hit),
    .stat_hit(stat_hit), .setup_hit(setup_hit), .queue_hit(queue_hit),
    .go_hit(go_hit), .invalid_hit(invalid_hit), .bad_hit(bad_hit), .blk_out(blk)
  );

  nand_mpe_plane_q #(.PLANE_BITS(PLANE_BITS), .BLOCK_BITS(BLOCK_BITS)) u_q (
    .clk(clk), .rst_n(rst_n),
    .wr_en(queue_hit || go_hit), .wr_plane(blk[PLANE_BITS-1:0]), .wr_block(blk),
    .clr(reset_hit || invalid_hit || bad_hit),
    .take_en(take), .take_plane(pick_idx),
    .valid_mask(vmask), .blocks(blocks)
  );

  nand_mpe_timer #(.CNT_W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(queue_hit || go_hit),
    .len_m1(queue_hit ? TW'(SHORT_BUSY - 1) : TW'(ERASE_BUSY - 1)),
    .abort(reset_hit), .running(t_running), .done(t_done)
  );

  nand_mpe_pick #(.PLANE_BITS(PLANE_BITS)) u_pick (
    .mask(vmask), .any(any_q), .idx(pick_idx)
  );

  assign ev_valid = (phase_q == PH_REPORT) && any_q;
  assign ev_plane = pick_idx;
  assign ev_block = blocks[pick_idx];
  assign take     = ev_valid && ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_READY;
    end else if (reset_hit) begin
      phase_q <= PH_READY;
    end else begin
      case (phase_q)
        PH_READY:  if (queue_hit) phase_q <= PH_SHORT;
                   else if (go_hit) phase_q <= PH_ERASE;
        PH_SHORT:  if (t_done || !t_running) phase_q <= PH_READY;
        PH_ERASE:  if (t_done || !t_running) phase_q <= PH_REPORT;
        PH_REPORT: if (!any_q) phase_q <= PH_READY;
        default:   phase_q <= PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q    <= 1'b0;
      stat_en_q <= 1'b0;
    end else begin
      if (reset_hit || setup_hit) fail_q <= 1'b0;
      else if (bad_hit)           fail_q <= 1'b1;
      if (cmd_strobe) stat_en_q <= stat_hit;
    end
  end

  assign stat_en = stat_en_q;

  always_comb begin
    stat_byte = 8'h00;
    if (stat_en_q) begin
      stat_byte[STAT_RDY_BIT]  = rdy;
      stat_byte[STAT_ARDY_BIT] = ardy;
      stat_byte[STAT_FAIL_BIT] = fail_q;
    end
  end
endmodule

// File: rtl/nand_mpe_chk.sv
module nand_mpe_chk #(
  parameter int PLANE_BITS = 2,
  parameter int BLOCK_BITS = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic                  cle,
  input logic [7:0]            din,
  input logic                  rdy,
  input logic                  ardy,
  input logic                  rb_drive_low,
  input logic                  stat_en,
  input logic [7:0]            stat_byte,
  input logic                  ev_valid,
  input logic                  ev_ready,
  input logic [PLANE_BITS-1:0] ev_plane,
  input logic [BLOCK_BITS-1:0] ev_block
);
  assert_report_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !rdy);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_plane) && $stable(ev_block)));

  assert_status_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en |-> (stat_byte[7] == 1'b0 && stat_byte[4:1] == 4'b0000 &&
                 stat_byte[6] == rdy && stat_byte[5] == ardy));

  assert_pin_tracks_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_drive_low == !rdy);

  assert_reset_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && cle && din == 8'hFF) |=> (rdy && !ev_valid));
endmodule

bind nand_mp_erase nand_mpe_chk #(.PLANE_BITS(PLANE_BITS), .BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cle(cle), .din(din), .rdy(rdy),
  .ardy(ardy), .rb_drive_low(rb_drive_low), .stat_en(stat_en), .stat_byte(stat_byte),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_plane(ev_plane), .ev_block(ev_block)
);

// File: tb/nand_mp_erase_tb_top.sv
module nand_mp_erase_tb_top;
  localparam int PB = 2;
  localparam int BB = 12;
  localparam int SHORT_BUSY = 12;
  localparam int ERASE_BUSY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, cle = 1'b0, ale = 1'b0;
  logic [7:0] din = 8'h00;
  logic rdy, ardy, rb_drive_low, stat_en, ev_valid;
  logic ev_ready = 1'b1;
  logic [7:0] stat_byte;
  logic [PB-1:0] ev_plane;
  logic [BB-1:0] ev_block;

  always #4 clk = ~clk;

  nand_mp_erase #(.PLANE_BITS(PB), .BLOCK_BITS(BB), .SHORT_BUSY(SHORT_BUSY),
                  .ERASE_BUSY(ERASE_BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cle(cle), .ale(ale), .din(din),
    .rdy(rdy), .ardy(ardy), .rb_drive_low(rb_drive_low), .stat_en(stat_en),
    .stat_byte(stat_byte), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_plane(ev_plane), .ev_block(ev_block)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R4";
  bit bp_on = 1'b0;
  int cyc = 0;

  typedef struct packed { logic [PB-1:0] p; logic [BB-1:0] b; } ev_t;
  ev_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    ev_ready <= bp_on ? ((cyc % 3) == 0) : 1'b1;
  end

  // Scoreboard monitor
  logic stall_seen = 1'b0;
  logic [PB-1:0] st_p;
  logic [BB-1:0] st_b;
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (stall_seen) begin
        chk(ev_valid && ev_plane == st_p && ev_block == st_b, "R6 hold",
            int'({ev_plane, ev_block}), int'({st_p, st_b}));
      end
      stall_seen = ev_valid && !ev_ready;
      st_p = ev_plane;
      st_b = ev_block;
      if (ev_valid && ev_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected event"}, int'({ev_plane, ev_block}), 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(ev_plane == e.p && ev_block == e.b, {cur_tag, " event"},
              int'({ev_plane, ev_block}), int'({e.p, e.b}));
        end
      end
    end
  end

  task automatic put_byte(input logic c, input logic a, input logic [7:0] d);
    bus_we = 1'b1; cle = c; ale = a; din = d;
    @(negedge clk);
    bus_we = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    put_byte(1'b1, 1'b0, d);
  endtask

  function automatic logic [23:0] mk_row(input logic [BB-1:0] blk, input logic [5:0] pg,
                                         input logic [5:0] hi);
    return {hi, blk, pg};
  endfunction

  task automatic addr_row(input logic [23:0] row);
    put_byte(1'b0, 1'b1, row[7:0]);
    put_byte(1'b0, 1'b1, row[15:8]);
    put_byte(1'b0, 1'b1, row[23:16]);
  endtask

  task automatic erase_cmd(input logic [7:0] conf, input logic [BB-1:0] blk,
                           input logic [5:0] pg);
    cmd(8'h60);
    addr_row(mk_row(blk, pg, 6'd0));
    cmd(conf);
  endtask

  task automatic push_exp(input logic [PB-1:0] p, input logic [BB-1:0] b);
    ev_t e;
    e.p = p; e.b = b;
    exp_q.push_back(e);
  endtask

  task automatic count_ready(output int n);
    n = 0;
    while (!rdy && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic count_erase(output int n);
    n = 0;
    while (!rdy && !ev_valid && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_erase(input string tag);
    int n;
    count_ready(n);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all events seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy && ardy && !rb_drive_low && !stat_en && !ev_valid, "R1 reset outputs",
        int'({rdy, ardy, rb_drive_low, stat_en, ev_valid}), 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: queue block 5 (plane 1), page bits set
    cur_tag = "R2";
    erase_cmd(8'hD1, 12'd5, 6'h2A);
    chk(!rdy && !ardy && rb_drive_low, "R3 busy after queue", rdy, 0);
    count_ready(n);
    chk(n == SHORT_BUSY, "R3 short busy length", n, SHORT_BUSY);
    chk(!ev_valid, "R3 no event after short busy", ev_valid, 0);
    erase_cmd(8'hD1, 12'd10, 6'h3F); count_ready(n);
    erase_cmd(8'hD1, 12'd255, 6'h01); count_ready(n);
    // R4/R6 final with back-pressure
    cur_tag = "R4";
    bp_on = 1'b1;
    push_exp(2'd0, 12'h100); push_exp(2'd1, 12'd5);
    push_exp(2'd2, 12'd10);  push_exp(2'd3, 12'd255);
    erase_cmd(8'hD0, 12'h100, 6'h00);
    count_erase(n);
    chk(n == ERASE_BUSY, "R4 erase busy length", n, ERASE_BUSY);
    finish_erase("R6");
    bp_on = 1'b0;

    // R5 replacement
    cur_tag = "R5";
    erase_cmd(8'hD1, 12'd5, 6'h00); count_ready(n);
    erase_cmd(8'hD1, 12'd9, 6'h00); count_ready(n);
    push_exp(2'd1, 12'd9); push_exp(2'd2, 12'd2);
    erase_cmd(8'hD0, 12'd2, 6'h00);
    finish_erase("R5");

    // R9/R13 empty queue single block, R8 status while busy
    cur_tag = "R9";
    push_exp(2'd3, 12'd7);
    erase_cmd(8'hD0, 12'd7, 6'h00);
    cmd(8'h70);
    chk(stat_en && stat_byte == 8'h00 && rb_drive_low, "R8 status busy",
        stat_byte, 8'h00);
    finish_erase("R13");
    cmd(8'h78);
    chk(stat_en && stat_byte == 8'h60 && !rb_drive_low, "R8 status ready",
        stat_byte, 8'h60);

    // R7 commands ignored while busy
    cur_tag = "R7";
    erase_cmd(8'hD1, 12'd6, 6'h00);
    cmd(8'h60); addr_row(mk_row(12'd1, 6'd0, 6'd0)); cmd(8'hD0);
    count_ready(n);
    chk(n == SHORT_BUSY - 5, "R7 busy not extended", n, SHORT_BUSY - 5);
    push_exp(2'd0, 12'd12); push_exp(2'd2, 12'd6);
    erase_cmd(8'hD0, 12'd12, 6'h00);
    finish_erase("R7");

    // R10 reset: clears queue, aborts erase
    cur_tag = "R10";
    erase_cmd(8'hD1, 12'd3, 6'h00); count_ready(n);
    cmd(8'hFF);
    push_exp(2'd0, 12'd8);
    erase_cmd(8'hD0, 12'd8, 6'h00);
    finish_erase("R10");
    erase_cmd(8'hD0, 12'd1, 6'h00);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    chk(rdy && !rb_drive_low, "R10 abort ready", rdy, 1);
    repeat (ERASE_BUSY + 5) @(negedge clk);
    chk(!ev_valid && rdy, "R10 no events after abort", ev_valid, 0);

    // R11 invalid opcode and short address
    cur_tag = "R11";
    erase_cmd(8'hD1, 12'd1, 6'h00); count_ready(n);
    cmd(8'h90);
    cmd(8'h60);
    put_byte(1'b0, 1'b1, 8'h80); put_byte(1'b0, 1'b1, 8'h00);
    cmd(8'hD0);
    chk(rdy, "R11 short address no busy", rdy, 1);
    push_exp(2'd2, 12'd2);
    erase_cmd(8'hD0, 12'd2, 6'h00);
    finish_erase("R11");

    // R12 out of range address
    cur_tag = "R12";
    erase_cmd(8'hD1, 12'd5, 6'h00); count_ready(n);
    cmd(8'h60); addr_row(mk_row(12'd3, 6'd0, 6'h01)); cmd(8'hD1);
    chk(rdy, "R12 stays ready", rdy, 1);
    cmd(8'h70);
    chk(stat_byte == 8'h61, "R12 fail flag", stat_byte, 8'h61);
    cmd(8'h60);
    cmd(8'h70);
    chk(stat_byte == 8'h60, "R12 fail cleared", stat_byte, 8'h60);
    push_exp(2'd3, 12'd3);
    addr_row(mk_row(12'd3, 6'd0, 6'd0)); cmd(8'hD0);
    finish_erase("R12");

    summary();
  end
endmodule